// File: doc/BRIEF.md
# I2C Bus Activity Status Monitor

This block observes the SCL and SDA wires of an I2C bus from inside a controller's clock domain. It reports bus conditions and occupancy as flags. Both wires pass through two-flop synchronizers. After synchronization, a falling SDA while SCL stays high counts as a START, including a repeated START. A rising SDA while SCL stays high counts as a STOP. Each condition gives a one-cycle pulse.

From these events the block keeps two occupancy flags.

- **Bus busy.** A master uses this flag to decide whether it may begin a transfer without colliding with another master. The flag sets on a START. It also sets whenever synchronized SCL is low, so that a bus joined mid-transfer is still seen as occupied. Only a STOP clears it.
- **Slave busy.** This flag tells local logic that this node's slave side is engaged. An address match pulse sets it. A START, a STOP or a bus error pulse clears it.

A start-on-idle request from the master side waits while the bus is busy. It is granted with a single pulse once the bus is idle. All flags, together with two direction bits, are packed into one status word.

Top module: `i2c_bus_monitor`

## Requirements
- R1: After the asynchronous reset, `status_o` is all zeros and no START, STOP or grant pulse is output until a qualifying event occurs.
- R2: An SDA falling edge seen while SCL is high (after the two-flop synchronizers) produces exactly one single-cycle pulse on `start_det_o`.
- R3: An SDA rising edge seen while SCL is high produces exactly one single-cycle pulse on `stop_det_o`.
- R4: SDA changes while SCL is low, and SCL edges while SDA is steady, produce no START or STOP pulse.
- R5: Bus busy (`status_o` bit 0) becomes 1 after a START.
- R6: Bus busy becomes 1 whenever synchronized SCL is low, even with no START seen.
- R7: Bus busy returns to 0 only after a STOP; SCL going high again does not clear it.
- R8: While `enable` is 0, bus busy, slave busy and both direction bits read 0, and no START, STOP or grant pulse is produced.
- R9: An `addr_match` pulse sets slave busy (`status_o` bit 2).
- R10: Slave busy clears on START, repeated START, STOP or `bus_error`. If a clear event and `addr_match` occur in the same cycle, the clear wins.
- R11: `status_o` bit 4 holds the `addr_rw` value captured at the address match (1 = slave read) and clears with slave busy. Bit 5 is `mst_read` registered. All other bits are 0.
- R12: An `idle_start_req` pulse made while bus busy is 1 is held pending with no grant. A single `idle_start_grant_o` pulse follows once bus busy is 0. A request made while the bus is idle is granted on the next cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| enable | input | 1 | Block enable; 0 forces flags to 0 |
| scl_in | input | 1 | Raw SCL wire level |
| sda_in | input | 1 | Raw SDA wire level |
| addr_match | input | 1 | Pulse: this node's slave address matched |
| addr_rw | input | 1 | Direction bit of the matched address (1 = read) |
| bus_error | input | 1 | Pulse: bus error detected |
| mst_read | input | 1 | Local master is performing a read |
| idle_start_req | input | 1 | Pulse: request to start once the bus is idle |
| start_det_o | output | 1 | One-cycle START / repeated START pulse |
| stop_det_o | output | 1 | One-cycle STOP pulse |
| idle_start_grant_o | output | 1 | One-cycle grant for a start-on-idle request |
| status_o | output | STATUS_W | Packed status word |

## Verification
The bench drives SDA while SCL is low and raises SCL while SDA is held low. A detector that ignored SCL would report false START or STOP pulses there. It joins the bus with SCL low and no START seen, which a tracker keyed only on START would wrongly report as idle. It then lets SCL rise without a STOP, where a tracker that cleared on SCL high would drop busy too early. It raises an address match together with a bus error, so the wrong set/clear priority would leave slave busy stuck at 1. It also posts a start-on-idle request in mid-transfer, which a design without the pending hold would either grant at once or lose.

// File: rtl/i2c_mon_pkg.sv
package i2c_mon_pkg;

  localparam int BIT_BUS_BUSY   = 0;
  localparam int BIT_SLV_BUSY   = 2;
  localparam int BIT_SLV_READ   = 4;
  localparam int BIT_MST_READ   = 5;
  localparam int PACKED_W       = 8;

  // SDA falls while SCL is high across two consecutive samples.
  function automatic logic is_start(input logic scl_now, input logic scl_was,
                                    input logic sda_now, input logic sda_was);
    return scl_now & scl_was & sda_was & ~sda_now;
  endfunction

  // SDA rises while SCL is high across two consecutive samples.
  function automatic logic is_stop(input logic scl_now, input logic scl_was,
                                   input logic sda_now, input logic sda_was);
    return scl_now & scl_was & ~sda_was & sda_now;
  endfunction

  // Bus occupancy next-state: STOP frees, START or low SCL occupies.
  function automatic logic bus_next(input logic en, input logic start,
                                    input logic stop, input logic scl_low,
                                    input logic cur);
    if (!en)                  return 1'b0;
    else if (stop)            return 1'b0;
    else if (start | scl_low) return 1'b1;
    else                      return cur;
  endfunction

  function automatic logic [PACKED_W-1:0] pack_status(input logic bus_busy,
                                                      input logic slv_busy,
                                                      input logic slv_read,
                                                      input logic mst_rd);
    logic [PACKED_W-1:0] w;
    w = '0;
    w[BIT_BUS_BUSY] = bus_busy;
    w[BIT_SLV_BUSY] = slv_busy;
    w[BIT_SLV_READ] = slv_read;
    w[BIT_MST_READ] = mst_rd;
    return w;
  endfunction

endpackage

// File: rtl/i2c_mon_sync.sv
module i2c_mon_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  for (genvar i = 0; i < STAGES; i++) begin : g_stage
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[0] <= RST_VAL;
        else        stg[0] <= d;
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n)
        if (!rst_n) stg[i] <= RST_VAL;
        else        stg[i] <= stg[i-1];
    end
  end

  assign q = stg[STAGES-1];
endmodule

// File: rtl/i2c_mon_cond_detect.sv
module i2c_mon_cond_detect
  import i2c_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic scl_s,
  input  logic sda_s,
  output logic start_p,
  output logic stop_p,
  output logic scl_low
);
  logic scl_q, sda_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end

  assign start_p = enable & is_start(scl_s, scl_q, sda_s, sda_q);
  assign stop_p  = enable & is_stop(scl_s, scl_q, sda_s, sda_q);
  assign scl_low = enable & ~scl_s;
endmodule

// File: rtl/i2c_mon_busy_track.sv
module i2c_mon_busy_track
  import i2c_mon_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic start_p,
  input  logic stop_p,
  input  logic scl_low,
  input  logic addr_match,
  input  logic addr_rw,
  input  logic bus_error,
  output logic bus_busy,
  output logic slave_busy,
  output logic slave_read
);
  logic slv_clear;
  assign slv_clear = start_p | stop_p | bus_error;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) bus_busy <= 1'b0;
    else        bus_busy <= bus_next(enable, start_p, stop_p, scl_low, bus_busy);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      slave_busy <= 1'b0;
      slave_read <= 1'b0;
    end else if (!enable || slv_clear) begin
      slave_busy <= 1'b0;
      slave_read <= 1'b0;
    end else if (addr_match) begin
      slave_busy <= 1'b1;
      slave_read <= addr_rw;
    end
endmodule

// File: rtl/i2c_mon_idle_gate.sv
module i2c_mon_idle_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic enable,
  input  logic bus_busy,
  input  logic req,
  output logic grant
);
  logic pend_q, want;
  assign want = pend_q | req;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      pend_q <= 1'b0;
      grant  <= 1'b0;
    end else begin
      grant  <= enable & want & ~bus_busy;
      pend_q <= enable & want & bus_busy;
    end
endmodule

// File: rtl/i2c_bus_monitor.sv
module i2c_bus_monitor
  import i2c_mon_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STATUS_W    = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                enable,
  input  logic                scl_in,
  input  logic                sda_in,
  input  logic                addr_match,
  input  logic                addr_rw,
  input  logic                bus_error,
  input  logic                mst_read,
  input  logic                idle_start_req,
  output logic                start_det_o,
  output logic                stop_det_o,
  output logic                idle_start_grant_o,
  output logic [STATUS_W-1:0] status_o
);
  localparam int LINES = 2;

  logic [LINES-1:0] lines_s;
  logic scl_s, sda_s;
  logic start_p, stop_p, scl_low;
  logic bus_busy, slave_busy, slave_read;
  logic mst_rd_q, grant;

  i2c_mon_sync #(.W(LINES), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_in, sda_in}), .q(lines_s)
  );
  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  i2c_mon_cond_detect u_det (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_s(scl_s), .sda_s(sda_s),
    .start_p(start_p), .stop_p(stop_p), .scl_low(scl_low)
  );

  i2c_mon_busy_track u_busy (
    .clk(clk), .rst_n(rst_n), .enable(enable), .start_p(start_p),
    .stop_p(stop_p), .scl_low(scl_low), .addr_match(addr_match),
    .addr_rw(addr_rw), .bus_error(bus_error), .bus_busy(bus_busy),
    .slave_busy(slave_busy), .slave_read(slave_read)
  );

  i2c_mon_idle_gate u_gate (
    .clk(clk), .rst_n(rst_n), .enable(enable), .bus_busy(bus_busy),
    .req(idle_start_req), .grant(grant)
  );

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) mst_rd_q <= 1'b0;
    else        mst_rd_q <= enable & mst_read;

  assign start_det_o        = start_p;
  assign stop_det_o         = stop_p;
  assign idle_start_grant_o = grant;
  assign status_o = STATUS_W'(pack_status(bus_busy, slave_busy, slave_read, mst_rd_q));
endmodule

// File: rtl/i2c_bus_monitor_chk.sv
module i2c_bus_monitor_chk (
  input logic clk,
  input logic rst_n,
  input logic enable,
  input logic addr_match,
  input logic bus_error,
  input logic scl_s,
  input logic start_p,
  input logic stop_p,
  input logic bus_busy,
  input logic slave_busy,
  input logic grant
);
  assert_start_single_R2: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> !start_p);
  assert_stop_single_R3: assert property (@(posedge clk) disable iff (!rst_n)
    stop_p |=> !stop_p);
  assert_cond_needs_scl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (start_p || stop_p) |-> scl_s);
  assert_cond_exclusive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({start_p, stop_p}));
  assert_busy_on_start_R5: assert property (@(posedge clk) disable iff (!rst_n)
    start_p |=> bus_busy);
  assert_busy_on_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && !scl_s) |=> bus_busy);
  assert_free_only_stop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_busy) |-> ($past(stop_p) || !$past(enable)));
  assert_off_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !enable |=> (!bus_busy && !slave_busy));
  assert_match_sets_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (enable && addr_match && !bus_error && !start_p && !stop_p) |=> slave_busy);
  assert_error_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_error || start_p || stop_p) |=> !slave_busy);
  assert_grant_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    grant |-> !$past(bus_busy));
endmodule

bind i2c_bus_monitor i2c_bus_monitor_chk u_chk (
  .clk(clk), .rst_n(rst_n), .enable(enable), .addr_match(addr_match),
  .bus_error(bus_error), .scl_s(scl_s), .start_p(start_p), .stop_p(stop_p),
  .bus_busy(bus_busy), .slave_busy(slave_busy), .grant(grant)
);

// File: tb/i2c_bus_monitor_test.sv
module i2c_bus_monitor_test;
  localparam int SW = 32;
  localparam int NV = 17;
  // [9]scl [8]sda [7]addr_match [6]bus_error [5]addr_rw
  // [4]exp bus busy [3]exp slave busy [2]exp slave read [1]exp start [0]exp stop
  localparam logic [9:0] VEC [NV] = '{
    10'b11_000_000_00, 10'b10_000_100_10, 10'b00_000_100_00, 10'b00_101_111_00,
    10'b01_000_111_00, 10'b11_000_111_00, 10'b10_000_100_10, 10'b00_000_100_00,
    10'b00_100_110_00, 10'b10_000_110_00, 10'b11_000_000_01, 10'b01_000_100_00,
    10'b11_000_100_00, 10'b10_000_100_10, 10'b10_101_111_00, 10'b10_010_100_00,
    10'b11_000_000_01 };

  logic clk = 0, rst_n = 0, enable = 0, scl = 1, sda = 1;
  logic am = 0, rw = 0, be = 0, mrd = 0, req = 0;
  logic st, sp, gr;
  logic [SW-1:0] status;
  int n_start = 0, n_stop = 0, n_grant = 0;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  i2c_bus_monitor #(.STATUS_W(SW)) uut (
    .clk(clk), .rst_n(rst_n), .enable(enable), .scl_in(scl), .sda_in(sda),
    .addr_match(am), .addr_rw(rw), .bus_error(be), .mst_read(mrd),
    .idle_start_req(req), .start_det_o(st), .stop_det_o(sp),
    .idle_start_grant_o(gr), .status_o(status)
  );

  always @(posedge clk) begin
    if (st) n_start++;
    if (sp) n_stop++;
    if (gr) n_grant++;
  end

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req_tag, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    int s0, p0, g0;
    idle(3);
    chk("R1 status after reset", int'(status), 0);
    rst_n = 1; idle(4);
    chk("R1 status idle", int'(status), 0);
    chk("R1 no pulses", n_start + n_stop + n_grant, 0);

    // R8: disabled, lines toggling yield nothing
    scl = 0; idle(4); sda = 0; idle(4); scl = 1; idle(4); sda = 1; idle(4);
    chk("R8 disabled status", int'(status), 0);
    chk("R8 disabled pulses", n_start + n_stop, 0);

    enable = 1; idle(4);
    // table walk (R2..R7, R9..R11)
    for (int i = 0; i < NV; i++) begin
      s0 = n_start; p0 = n_stop;
      scl = VEC[i][9]; sda = VEC[i][8]; am = VEC[i][7]; be = VEC[i][6]; rw = VEC[i][5];
      idle(1); am = 0; be = 0; rw = 0;
      idle(5);
      chk($sformatf("R5/R6/R7 bus busy step %0d", i), int'(status[0]), int'(VEC[i][4]));
      chk($sformatf("R9/R10 slave busy step %0d", i), int'(status[2]), int'(VEC[i][3]));
      chk($sformatf("R11 slave read step %0d", i), int'(status[4]), int'(VEC[i][2]));
      chk($sformatf("R2/R4 start count step %0d", i), n_start - s0, int'(VEC[i][1]));
      chk($sformatf("R3/R4 stop count step %0d", i), n_stop - p0, int'(VEC[i][0]));
      chk($sformatf("R11 spare bits step %0d", i), int'(status & 32'hFFFF_FFCA), 0);
    end

    // R10: clear wins over simultaneous match
    am = 1; be = 1; rw = 1; idle(1); am = 0; be = 0; rw = 0; idle(3);
    chk("R10 clear beats match", int'(status[2]), 0);

    // R11: master read bit
    mrd = 1; idle(3);
    chk("R11 master read bit5", int'(status[5]), 1);
    mrd = 0; idle(3);
    chk("R11 master read low", int'(status[5]), 0);

    // R12: request while busy is held pending
    sda = 0; idle(5); scl = 0; idle(5);
    chk("R6 busy before request", int'(status[0]), 1);
    g0 = n_grant;
    req = 1; idle(1); req = 0; idle(8);
    chk("R12 no grant while busy", n_grant - g0, 0);
    scl = 1; idle(5); sda = 1; idle(8);
    chk("R7 idle after stop", int'(status[0]), 0);
    chk("R12 pending granted once", n_grant - g0, 1);
    g0 = n_grant;
    req = 1; idle(1); req = 0; idle(3);
    chk("R12 idle request granted", n_grant - g0, 1);

    // R8: disabling clears an occupied bus
    scl = 0; idle(5); am = 1; idle(1); am = 0; idle(2);
    chk("R8 busy before disable", int'(status[0]), 1);
    enable = 0; idle(2);
    chk("R8 disable forces zero", int'(status), 0);
    scl = 1; idle(4); enable = 1; idle(4);
    chk("R7 re-enable on high lines stays idle", int'(status[0]), 0);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule